// File: doc/BRIEF.md
# Multi-byte Command Port Controller

This block is the processor-facing command front end of a time/space switch. A host writes short commands over an 8-bit bus. Each command is a few data bytes (C/D low) followed by one command byte (C/D high). The data bytes build up in a small stack. When the command byte arrives, its opcode and byte count are checked, and the command then becomes a write to the connection memory, a read of it, a read of an output channel, or a channel-zero mask load for the extraction engine. The connection memory, the output-channel data path and the extraction engine all sit outside the block and are reached through request ports.

The device is fully selected when both chip selects are low and each select input matches its strap. With the chip selects alone, some commands change meaning, so one bus write can address a group of devices at once. A data-ready output reports a bad command by staying low. It reports a pending message by dropping for two clocks. Two result registers can be read back with the read strobe, and C/D chooses between them.

Top module: `cmd_port_ctrl`

## Requirements
- R1: A write completes on the rising edge of `wr_n` while `rd_n` is high and both chip selects are low. With `cd` low the byte is a data byte; with `cd` high it is the command byte, and its bits 3..0 are the opcode. A line number is taken from byte bits 2..0 and a channel from bits 4..0. Higher bits are ignored.
- R2: The stack keeps the first four data bytes and ignores any later ones. It is emptied by every command byte. A command with fewer data bytes than it needs (four for connect and insert, two for the others) is rejected in the same way as an invalid opcode.
- R3: Connect (opcode 0001, bytes: input line, input channel, output line, output channel) under full selection writes word {0, in_line, in_chan} at address out_line*32+out_chan. It sets result register A to the low 8 bits of that word and result register B to {out_line, word bit 8, opcode}.
- R4: Insert (opcode 0100, bytes: message bits 7..5, message bits 4..0, output line, output channel) under full selection writes {1, message} to the addressed word. A and B are set as in R3.
- R5: Under chip-select-only selection, connect and insert write all ones (9'h1FF) instead. Extract and disconnect then do nothing: no request is made, the results are kept and data-ready stays high.
- R6: Disconnect (opcode 0010, bytes: line, channel) under full selection writes all ones to the addressed word. A and B are set as in R3.
- R7: Read-word (opcode 1000, bytes: line, channel) needs only the chip selects. It loads A with word bits 7..0 and B with {line, word bit 8, 1000}. If bit 8 is set and bits 7..0 are not all ones, data-ready goes low for exactly two clocks.
- R8: Extract (opcode 1011, bytes: line, channel) under full selection loads A with the output channel byte and B with {line, source flag, 1011}. The source flag is 1 when the byte is a stored message.
- R9: Mask (opcode 1110, two bytes) under full selection pulses `mask_we` for one clock with mask {byte1[2:0], byte2[4:0]}. It sets B to {000, mask nonzero, 1110} and keeps A.
- R10: An invalid opcode or a rejected command drives data-ready low until a valid opcode is accepted. It changes neither result register and makes no request.
- R11: Reading with `rd_n` low, `wr_n` high and full selection drives `dout` with A when `cd` is low and with B when `cd` is high. The bus is not driven at any other time.
- R12: While `rd_n` and `wr_n` are both low, the bus is not driven and a pending memory result is held. It loads once the condition ends.
- R13: After reset data-ready is high, both result registers are zero and no request is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_n | input | 1 | Write strobe, active low, byte taken on release |
| rd_n | input | 1 | Read strobe, active low |
| cs_a_n | input | 1 | First chip select, active low |
| cs_b_n | input | 1 | Second chip select, active low |
| cd | input | 1 | Command/data select; on reads, result register select |
| sel_a | input | 1 | First address select |
| strap_a | input | 1 | Value `sel_a` must equal for full selection |
| sel_b | input | 1 | Second address select |
| strap_b | input | 1 | Value `sel_b` must equal for full selection |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Read data drive enable |
| rdy | output | 1 | Data-ready handshake |
| cm_req | output | 1 | Connection memory request, one clock |
| cm_we | output | 1 | Connection memory write enable |
| ch_addr | output | 8 | Channel address {line, channel} |
| cm_wdata | output | 9 | Connection memory write word |
| cm_rdata | input | 9 | Connection memory read word, valid the clock after the request |
| ext_req | output | 1 | Output channel read request, one clock |
| ext_rdata | input | 8 | Output channel byte, valid the clock after the request |
| ext_src_cm | input | 1 | Output channel byte came from a stored message |
| mask_we | output | 1 | Mask load pulse to the extraction engine |
| mask_data | output | 8 | Mask value |

## Verification
The assertions assume the host never completes a write while a read or freeze is in progress. They also assume the select and strap inputs, C/D and the data bus are stable at the clock edge that sees `wr_n` rise, and that memory read data does not change while a result is pending. The bench keeps to these rules by changing every input on the falling clock edge. It holds data and C/D for two clocks after each write strobe is released, and changes the selects only between commands. Its memory models update read data only when a request arrives.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    localparam logic [3:0] OP_CONNECT    = 4'b0001;
    localparam logic [3:0] OP_DISCONNECT = 4'b0010;
    localparam logic [3:0] OP_INSERT     = 4'b0100;
    localparam logic [3:0] OP_READCW     = 4'b1000;
    localparam logic [3:0] OP_EXTRACT    = 4'b1011;
    localparam logic [3:0] OP_MASK       = 4'b1110;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_BAD,
        ACT_WRITE,
        ACT_READCW,
        ACT_EXTRACT,
        ACT_MASK
    } cpc_act_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT,
        PH_TAKE
    } cpc_phase_e;

endpackage

// File: rtl/cpc_strobe.sv
module cpc_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    input  logic rd_n,
    input  logic cs_a_n,
    input  logic cs_b_n,
    input  logic cd,
    input  logic sel_a,
    input  logic strap_a,
    input  logic sel_b,
    input  logic strap_b,
    output logic data_evt,
    output logic cmd_evt,
    output logic full_sel,
    output logic frozen
);
    logic wr_d, wr_q;
    logic cs_ok, wr_done;

    always_comb begin
        wr_d     = wr_n;
        cs_ok    = !cs_a_n && !cs_b_n;
        full_sel = cs_ok && (sel_a == strap_a) && (sel_b == strap_b);
        frozen   = !rd_n && !wr_n;
        wr_done  = wr_n && !wr_q && rd_n && cs_ok;
        data_evt = wr_done && !cd;
        cmd_evt  = wr_done && cd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= 1'b1;
        else        wr_q <= wr_d;
    end
endmodule

// File: rtl/cpc_stack.sv
module cpc_stack #(
    parameter int DW    = 8,
    parameter int SLOTS = 4,
    localparam int CNTW = $clog2(SLOTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  logic                  clear,
    input  logic [DW-1:0]         din,
    output logic [CNTW-1:0]       cnt,
    output logic [SLOTS*DW-1:0]   flat
);
    logic [CNTW-1:0]            cnt_d, cnt_q;
    logic [SLOTS-1:0][DW-1:0]   slot_d, slot_q;

    always_comb begin
        cnt_d  = cnt_q;
        slot_d = slot_q;
        if (clear) begin
            cnt_d = '0;
        end else if (push && cnt_q < CNTW'(SLOTS)) begin
            cnt_d = cnt_q + 1'b1;
            for (int i = 0; i < SLOTS; i++) begin
                if (cnt_q == CNTW'(i)) slot_d[i] = din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            slot_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            slot_q <= slot_d;
        end
    end

    assign cnt  = cnt_q;
    assign flat = slot_q;
endmodule

// File: rtl/cpc_decode.sv
module cpc_decode
    import cpc_pkg::*;
#(
    parameter int LW    = 3,
    parameter int CW    = 5,
    parameter int SLOTS = 4,
    localparam int DW   = LW + CW,
    localparam int CMW  = DW + 1,
    localparam int CNTW = $clog2(SLOTS + 1)
) (
    input  logic [3:0]            op,
    input  logic [CNTW-1:0]       cnt,
    input  logic [SLOTS*DW-1:0]   flat,
    input  logic                  full,
    output cpc_act_e              act,
    output logic [DW-1:0]         addr,
    output logic [CMW-1:0]        wdata,
    output logic [LW-1:0]         line,
    output logic [DW-1:0]         mask
);
    logic [DW-1:0] b0, b1, b2, b3;
    logic [CNTW-1:0] need;
    logic known;

    always_comb begin
        b0 = flat[0*DW +: DW];
        b1 = flat[1*DW +: DW];
        b2 = flat[2*DW +: DW];
        b3 = flat[3*DW +: DW];

        known = 1'b1;
        need  = CNTW'(2);
        case (op)
            OP_CONNECT, OP_INSERT:                   need = CNTW'(4);
            OP_DISCONNECT, OP_READCW,
            OP_EXTRACT, OP_MASK:                     need = CNTW'(2);
            default:                                 known = 1'b0;
        endcase

        line  = b0[LW-1:0];
        addr  = {b0[LW-1:0], b1[CW-1:0]};
        mask  = {b0[LW-1:0], b1[CW-1:0]};
        wdata = '1;
        act   = ACT_NONE;

        if (!known || cnt < need) begin
            act = ACT_BAD;
        end else begin
            case (op)
                OP_CONNECT, OP_INSERT: begin
                    line = b2[LW-1:0];
                    addr = {b2[LW-1:0], b3[CW-1:0]};
                    act  = ACT_WRITE;
                    if (full) wdata = {(op == OP_INSERT), b0[LW-1:0], b1[CW-1:0]};
                end
                OP_DISCONNECT: act = full ? ACT_WRITE : ACT_NONE;
                OP_EXTRACT:    act = full ? ACT_EXTRACT : ACT_NONE;
                OP_MASK:       act = full ? ACT_MASK : ACT_NONE;
                OP_READCW:     act = ACT_READCW;
                default:       act = ACT_BAD;
            endcase
        end
    end
endmodule

// File: rtl/cmd_port_ctrl.sv
module cmd_port_ctrl
    import cpc_pkg::*;
#(
    parameter int LINE_W  = 3,
    parameter int CHAN_W  = 5,
    parameter int DEPTH   = 5,
    parameter int PULSE   = 2,
    localparam int DW     = LINE_W + CHAN_W,
    localparam int CMW    = DW + 1,
    localparam int SLOTS  = DEPTH - 1,
    localparam int CNTW   = $clog2(SLOTS + 1),
    localparam int PW     = $clog2(PULSE + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_n,
    input  logic           rd_n,
    input  logic           cs_a_n,
    input  logic           cs_b_n,
    input  logic           cd,
    input  logic           sel_a,
    input  logic           strap_a,
    input  logic           sel_b,
    input  logic           strap_b,
    input  logic [DW-1:0]  din,
    output logic [DW-1:0]  dout,
    output logic           dout_oe,
    output logic           rdy,
    output logic           cm_req,
    output logic           cm_we,
    output logic [DW-1:0]  ch_addr,
    output logic [CMW-1:0] cm_wdata,
    input  logic [CMW-1:0] cm_rdata,
    output logic           ext_req,
    input  logic [DW-1:0]  ext_rdata,
    input  logic           ext_src_cm,
    output logic           mask_we,
    output logic [DW-1:0]  mask_data
);
    typedef struct packed {
        logic [DW-1:0]     res_a;
        logic [DW-1:0]     res_b;
        logic              bad;
        logic [PW-1:0]     pulse;
        cpc_phase_e        phase;
        logic              pend_ext;
        logic [LINE_W-1:0] pend_line;
        logic              cm_req;
        logic              cm_we;
        logic [DW-1:0]     addr;
        logic [CMW-1:0]    wdata;
        logic              ext_req;
        logic              mask_we;
        logic [DW-1:0]     mask;
    } state_t;

    state_t s_d, s_q;

    logic data_evt, cmd_evt, full_sel, frozen;
    logic [CNTW-1:0]     stk_cnt;
    logic [SLOTS*DW-1:0] stk_flat;
    cpc_act_e            act;
    logic [DW-1:0]       dec_addr, dec_mask;
    logic [CMW-1:0]      dec_wdata;
    logic [LINE_W-1:0]   dec_line;

    cpc_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
        .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .cd(cd),
        .sel_a(sel_a), .strap_a(strap_a), .sel_b(sel_b), .strap_b(strap_b),
        .data_evt(data_evt), .cmd_evt(cmd_evt), .full_sel(full_sel), .frozen(frozen)
    );

    cpc_stack #(.DW(DW), .SLOTS(SLOTS)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(data_evt), .clear(cmd_evt),
        .din(din), .cnt(stk_cnt), .flat(stk_flat)
    );

    cpc_decode #(.LW(LINE_W), .CW(CHAN_W), .SLOTS(SLOTS)) u_decode (
        .op(din[3:0]), .cnt(stk_cnt), .flat(stk_flat), .full(full_sel),
        .act(act), .addr(dec_addr), .wdata(dec_wdata), .line(dec_line), .mask(dec_mask)
    );

    always_comb begin
        s_d         = s_q;
        s_d.cm_req  = 1'b0;
        s_d.ext_req = 1'b0;
        s_d.mask_we = 1'b0;
        if (s_q.pulse != '0) s_d.pulse = s_q.pulse - 1'b1;

        case (s_q.phase)
            PH_WAIT: s_d.phase = PH_TAKE;
            PH_TAKE: begin
                if (!frozen) begin
                    s_d.phase = PH_IDLE;
                    if (s_q.pend_ext) begin
                        s_d.res_a = ext_rdata;
                        s_d.res_b = {s_q.pend_line, ext_src_cm, OP_EXTRACT};
                    end else begin
                        s_d.res_a = cm_rdata[DW-1:0];
                        s_d.res_b = {s_q.pend_line, cm_rdata[CMW-1], OP_READCW};
                        if (cm_rdata[CMW-1] && cm_rdata[DW-1:0] != '1)
                            s_d.pulse = PW'(PULSE);
                    end
                end
            end
            default: ;
        endcase

        if (cmd_evt) begin
            s_d.bad = (act == ACT_BAD);
            case (act)
                ACT_WRITE: begin
                    s_d.cm_req = 1'b1;
                    s_d.cm_we  = 1'b1;
                    s_d.addr   = dec_addr;
                    s_d.wdata  = dec_wdata;
                    s_d.res_a  = dec_wdata[DW-1:0];
                    s_d.res_b  = {dec_line, dec_wdata[CMW-1], din[3:0]};
                end
                ACT_READCW, ACT_EXTRACT: begin
                    s_d.cm_req    = (act == ACT_READCW);
                    s_d.ext_req   = (act == ACT_EXTRACT);
                    s_d.cm_we     = 1'b0;
                    s_d.addr      = dec_addr;
                    s_d.pend_ext  = (act == ACT_EXTRACT);
                    s_d.pend_line = dec_line;
                    s_d.phase     = PH_WAIT;
                end
                ACT_MASK: begin
                    s_d.mask_we = 1'b1;
                    s_d.mask    = dec_mask;
                    s_d.res_b   = {LINE_W'(0), (dec_mask != '0), din[3:0]};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdy       = !s_q.bad && (s_q.pulse == '0);
    assign dout_oe   = !rd_n && wr_n && full_sel;
    assign dout      = cd ? s_q.res_b : s_q.res_a;
    assign cm_req    = s_q.cm_req;
    assign cm_we     = s_q.cm_we;
    assign ch_addr   = s_q.addr;
    assign cm_wdata  = s_q.wdata;
    assign ext_req   = s_q.ext_req;
    assign mask_we   = s_q.mask_we;
    assign mask_data = s_q.mask;
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
    parameter int CMW = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_n,
    input logic           rd_n,
    input logic           cs_a_n,
    input logic           cs_b_n,
    input logic           cd,
    input logic           sel_a,
    input logic           strap_a,
    input logic           sel_b,
    input logic           strap_b,
    input logic [7:0]     din,
    input logic           rdy,
    input logic           cm_req,
    input logic           cm_we,
    input logic [CMW-1:0] cm_wdata,
    input logic           ext_req,
    input logic           mask_we
);
    logic wr_seen_q;
    logic cmd_c, bad_op_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_seen_q <= 1'b1;
        else        wr_seen_q <= wr_n;
    end

    always_comb begin
        cmd_c    = wr_n && !wr_seen_q && rd_n && !cs_a_n && !cs_b_n && cd;
        bad_op_c = !(din[3:0] inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b1011, 4'b1110});
    end

    AST_CM_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cm_req |=> !cm_req); // R3
    AST_MASK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> !mask_we); // R9
    AST_KEEP_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cm_req) && cm_we && !cm_wdata[CMW-1]) |-> $past(sel_a == strap_a && sel_b == strap_b)); // R5
    AST_BAD_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_c && bad_op_c) |=> (!cm_req && !ext_req && !mask_we)); // R10
    AST_BAD_DROPS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_c && bad_op_c) |=> !rdy); // R10
    AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !wr_n && $past(!rd_n && !wr_n)) |-> (!cm_req && !ext_req && !mask_we)); // R12
endmodule

bind cmd_port_ctrl cpc_checker #(.CMW(CMW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
    .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .cd(cd),
    .sel_a(sel_a), .strap_a(strap_a), .sel_b(sel_b), .strap_b(strap_b),
    .din(din), .rdy(rdy), .cm_req(cm_req), .cm_we(cm_we), .cm_wdata(cm_wdata),
    .ext_req(ext_req), .mask_we(mask_we)
);

// File: tb/cmd_port_ctrl_test.sv
module cmd_port_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_n = 1'b1, rd_n = 1'b1, cs_a_n = 1'b0, cs_b_n = 1'b0, cd = 1'b0;
    logic sel_a = 1'b1, sel_b = 1'b0;
    logic strap_a = 1'b1, strap_b = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic dout_oe, rdy, cm_req, cm_we, ext_req, mask_we;
    logic [7:0] ch_addr, mask_data;
    logic [8:0] cm_wdata;
    logic [8:0] cm_rdata = '1;
    logic [7:0] ext_rdata = '0;
    logic ext_src_cm = 1'b0;

    int checks = 0;
    int fails = 0;
    int mask_cnt = 0;
    logic [7:0] mask_seen = '0;
    logic [8:0] cm_mem [256];

    always #5 clk = ~clk;

    cmd_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
        .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .cd(cd),
        .sel_a(sel_a), .strap_a(strap_a), .sel_b(sel_b), .strap_b(strap_b),
        .din(din), .dout(dout), .dout_oe(dout_oe), .rdy(rdy),
        .cm_req(cm_req), .cm_we(cm_we), .ch_addr(ch_addr), .cm_wdata(cm_wdata),
        .cm_rdata(cm_rdata), .ext_req(ext_req), .ext_rdata(ext_rdata),
        .ext_src_cm(ext_src_cm), .mask_we(mask_we), .mask_data(mask_data)
    );

    always @(posedge clk) begin
        if (cm_req) begin
            if (cm_we) cm_mem[ch_addr] <= cm_wdata;
            else       cm_rdata <= cm_mem[ch_addr];
        end
        if (ext_req) begin
            ext_src_cm <= cm_mem[ch_addr][8];
            ext_rdata  <= cm_mem[ch_addr][8] ? cm_mem[ch_addr][7:0] : (cm_mem[ch_addr][7:0] ^ 8'h5A);
        end
        if (mask_we) begin
            mask_cnt  <= mask_cnt + 1;
            mask_seen <= mask_data;
        end
    end

    typedef struct packed {
        logic [2:0]  nb;
        logic [39:0] b;
        logic [3:0]  op;
        logic        full;
        logic [7:0]  or1;
        logic [7:0]  or2;
        logic        rdy;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{3'd4, 40'h00_03_05_E7_E2, 4'h1, 1'b1, 8'h47, 8'hA1, 1'b1},
        '{3'd2, 40'h00_00_00_03_05, 4'h8, 1'b1, 8'h47, 8'hA8, 1'b1},
        '{3'd2, 40'h00_00_00_03_05, 4'hB, 1'b1, 8'h1D, 8'hAB, 1'b1},
        '{3'd4, 40'h00_1F_01_15_06, 4'h4, 1'b1, 8'hD5, 8'h34, 1'b1},
        '{3'd2, 40'h00_00_00_1F_01, 4'h8, 1'b1, 8'hD5, 8'h38, 1'b1},
        '{3'd2, 40'h00_00_00_1F_01, 4'hB, 1'b1, 8'hD5, 8'h3B, 1'b1},
        '{3'd4, 40'h00_03_05_04_04, 4'h1, 1'b0, 8'hFF, 8'hB1, 1'b1},
        '{3'd2, 40'h00_00_00_03_05, 4'h8, 1'b0, 8'hFF, 8'hB8, 1'b1},
        '{3'd2, 40'h00_00_00_1F_01, 4'hB, 1'b0, 8'hFF, 8'hB8, 1'b1},
        '{3'd2, 40'h00_00_00_1F_01, 4'h2, 1'b0, 8'hFF, 8'hB8, 1'b1},
        '{3'd2, 40'h00_00_00_1F_01, 4'h8, 1'b1, 8'hD5, 8'h38, 1'b1},
        '{3'd2, 40'h00_00_00_1F_01, 4'h2, 1'b1, 8'hFF, 8'h32, 1'b1},
        '{3'd2, 40'h00_00_00_1F_01, 4'h5, 1'b1, 8'hFF, 8'h32, 1'b0},
        '{3'd2, 40'h00_00_00_0A_05, 4'hE, 1'b1, 8'hFF, 8'h1E, 1'b1},
        '{3'd5, 40'h07_04_02_09_03, 4'h1, 1'b1, 8'h69, 8'h41, 1'b1},
        '{3'd1, 40'h00_00_00_00_02, 4'h8, 1'b1, 8'h69, 8'h41, 1'b0},
        '{3'd2, 40'h00_00_00_04_02, 4'h8, 1'b1, 8'h69, 8'h48, 1'b1}
    };
    localparam string TAG [NV] = '{
        "R3/R1", "R7", "R8", "R4", "R7", "R8", "R5", "R7", "R5",
        "R5", "R5", "R6", "R10", "R9", "R2", "R2", "R2"
    };

    task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic c, input logic [7:0] d);
        @(negedge clk); cd = c; din = d; wr_n = 1'b0;
        @(negedge clk);
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rd_reg(input logic c, output logic [7:0] d, output logic oe);
        @(negedge clk); cd = c; rd_n = 1'b0;
        #1; d = dout; oe = dout_oe;
        @(negedge clk); rd_n = 1'b1; cd = 1'b0;
    endtask

    task automatic send_cmd(input int nb, input logic [39:0] b, input logic [3:0] op);
        for (int k = 0; k < nb; k++) wr_byte(1'b0, b[8*k +: 8]);
        wr_byte(1'b1, 8'hE0 | {4'h0, op});
    endtask

    task automatic run_vec(input int i);
        logic [7:0] d;
        logic oe;
        sel_a = VEC[i].full;
        send_cmd(int'(VEC[i].nb), VEC[i].b, VEC[i].op);
        repeat (3) @(negedge clk);
        sel_a = 1'b1;
        rd_reg(1'b0, d, oe);
        chk(oe && d == VEC[i].or1, TAG[i], {7'd0, oe, d}, {8'h01, VEC[i].or1});
        rd_reg(1'b1, d, oe);
        chk(oe && d == VEC[i].or2, TAG[i], {7'd0, oe, d}, {8'h01, VEC[i].or2});
        chk(rdy == VEC[i].rdy, TAG[i], {15'd0, rdy}, {15'd0, VEC[i].rdy});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic oe;
        for (int a = 0; a < 256; a++) cm_mem[a] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: reset state
        chk(rdy == 1'b1 && !cm_req && !ext_req && !mask_we, "R13", {15'd0, rdy}, 16'd1);
        chk(dout_oe == 1'b0, "R13", {15'd0, dout_oe}, 16'd0);
        rd_reg(1'b0, d, oe);
        chk(oe && d == 8'h00, "R13", {7'd0, oe, d}, 16'h0100);
        rd_reg(1'b1, d, oe);
        chk(oe && d == 8'h00, "R13", {7'd0, oe, d}, 16'h0100);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R9: mask value delivered once
        chk(mask_cnt == 1 && mask_seen == 8'hAA, "R9", {mask_cnt[7:0], mask_seen}, 16'h01AA);

        // R11: partial selection does not drive the bus
        sel_a = 1'b0;
        rd_reg(1'b0, d, oe);
        chk(oe == 1'b0, "R11", {15'd0, oe}, 16'd0);
        sel_a = 1'b1;

        // R7: two-clock data-ready pulse on a stored message
        send_cmd(4, 40'h00_1F_01_1C_01, 4'h4);
        send_cmd(2, 40'h00_00_00_1F_01, 4'h8);
        chk(rdy == 1'b1, "R7", {15'd0, rdy}, 16'd1);
        @(negedge clk);
        chk(rdy == 1'b0, "R7", {15'd0, rdy}, 16'd0);
        @(negedge clk);
        chk(rdy == 1'b0, "R7", {15'd0, rdy}, 16'd0);
        @(negedge clk);
        chk(rdy == 1'b1, "R7", {15'd0, rdy}, 16'd1);

        // R12: both strobes low hold the pending result
        wr_byte(1'b0, 8'h01);
        wr_byte(1'b0, 8'h1F);
        @(negedge clk); cd = 1'b1; din = 8'hE8; wr_n = 1'b0;
        @(negedge clk);
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); rd_n = 1'b0; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(dout_oe == 1'b0, "R12", {15'd0, dout_oe}, 16'd0);
        chk(rdy == 1'b1, "R12", {15'd0, rdy}, 16'd1);
        wr_n = 1'b1;
        @(negedge clk);
        chk(rdy == 1'b0, "R12", {15'd0, rdy}, 16'd0);
        rd_n = 1'b1; cd = 1'b0;
        repeat (3) @(negedge clk);
        rd_reg(1'b0, d, oe);
        chk(oe && d == 8'h3C, "R12", {7'd0, oe, d}, 16'h013C);
        rd_reg(1'b1, d, oe);
        chk(oe && d == 8'h38, "R12", {7'd0, oe, d}, 16'h0138);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule